// File: doc/BRIEF.md
# Dual-Edge Serial to 12-Bit Word Deserializer

This block turns one serial bit stream, sampled on both edges of a bit clock, into 12-bit parallel words. The bit clock runs at half the serial rate. Samples taken on rising edges move through one 6-stage flip-flop chain and samples taken on falling edges move through another. The falling chain is copied into rising-edge flops, and both chains are realigned and interleaved into one word. Every six clock cycles that word is written into a holding register, and a one-cycle valid strobe marks it. The holding register keeps each word steady for the whole word period, so slower logic downstream can pick it up at leisure.

Word timing comes from a small phase machine in the rising-edge domain. It has two states. PH_FILL counts the first five cycles of a word with a beat counter. PH_LAST is the cycle in which the word is written. Its transitions are: count (PH_FILL to PH_FILL, beat advances), arm (PH_FILL to PH_LAST when the beat reaches its end value), emit (PH_LAST to PH_FILL, holding-register load and valid strobe), and slip hold (either state stays unchanged while a slip request is sampled). Asserting reset forces PH_FILL with the beat at zero. Because each slip request holds the machine for one cycle, the upstream controller can move the word boundary by two serial bits at a time until its framing pattern lines up.

The shift-chain flops have no reset and no clear, and there is no logic between them. Their contents are undefined until a full word has been taken in after reset.

Top module: `ddr_word_deser`

## Requirements
- R1: While rst_n is low, word_valid is 0 and word_out is 0, with no clock edge needed. After reset is released, the first word_valid pulse follows the 6th rising edge of bit_clk.
- R2: Each word interleaves the two edge streams, starting with a rising-edge sample. Bit 11 holds the oldest rising-edge sample and bit 10 the falling-edge sample taken half a cycle after it, continuing down to bit 1 for the newest rising sample and bit 0 for the newest falling sample.
- R3: When no slip is requested, word_valid is high for exactly one cycle in every six.
- R4: A word whose newest falling sample is taken on the falling edge after rising edge k is visible on word_out, with word_valid high, right after rising edge k+2.
- R5: word_out changes only on the edges that raise word_valid. In every other cycle it keeps its value.
- R6: Each rising edge at which slip_req is high delays the next word and every later word by one cycle, which moves the word boundary by two serial bits. No word is written at that edge. Consecutive slip cycles add up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock at half the serial rate; data is sampled on both edges |
| rst_n | input | 1 | Active-low asynchronous reset for the phase machine, strobe and holding register |
| ser_in | input | 1 | Serial data input |
| slip_req | input | 1 | Sampled on rising edges; each high cycle holds the word phase for one cycle |
| word_out | output | 12 | Holding register carrying the most recent completed word |
| word_valid | output | 1 | One-cycle strobe marking a newly loaded word |

## Verification
If the phase machine holds a wrong state or beat value, the valid strobe moves away from its six-cycle spacing. That shows up at the next strobe, at most six cycles later. A misplaced alignment stage or a mis-wired interleave shows up as a wrong bit pattern in the very first checked word, since the stimulus uses asymmetric patterns, and it makes word_out change at an edge where it should hold. If a slip is not honoured, or honoured twice, every later strobe lands one cycle early or late. That is visible at the first strobe after the slip.

// File: rtl/ddrdes_pkg.sv
package ddrdes_pkg;

    // Phase of the word-assembly cycle, clocked on the rising edge.
    typedef enum logic [0:0] {
        PH_FILL = 1'b0,   // collecting beats 0 .. HALF_W-2
        PH_LAST = 1'b1    // final beat: holding register loads here
    } phase_t;

endpackage

// File: rtl/ddrdes_edge_chain.sv
// Plain flip-flop shift chain clocked on one chosen edge.
// No reset and no logic between stages, so each stage is a bare flop.
module ddrdes_edge_chain #(
    parameter int HALF_W    = 6,
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic              clk,
    input  logic              din,
    output logic [HALF_W-1:0] taps
);

    logic [HALF_W-1:0] sr_q;

    generate
        if (FALL_EDGE) begin : g_fall
            always_ff @(negedge clk) begin
                sr_q <= {sr_q[HALF_W-2:0], din};
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                sr_q <= {sr_q[HALF_W-2:0], din};
            end
        end
    endgenerate

    assign taps = sr_q;

endmodule

// File: rtl/ddrdes_phase_fsm.sv
// Word-phase machine: PH_FILL counts beats, PH_LAST triggers the load.
// A sampled slip request holds both state and beat for one cycle.
module ddrdes_phase_fsm
    import ddrdes_pkg::*;
#(
    parameter int HALF_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slip_req,
    output logic load_en,
    output logic word_valid
);

    localparam int BW = (HALF_W > 2) ? $clog2(HALF_W) : 1;
    localparam logic [BW-1:0] BEAT_END = BW'(HALF_W - 2);

    phase_t        state_q, state_d;
    logic [BW-1:0] beat_q,  beat_d;
    logic          valid_q;

    // Next state and load enable.
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        load_en = 1'b0;
        unique case (state_q)
            PH_FILL: begin
                if (!slip_req) begin
                    if (beat_q == BEAT_END) begin
                        state_d = PH_LAST;          // arm
                    end else begin
                        beat_d = beat_q + BW'(1);   // count
                    end
                end
            end
            PH_LAST: begin
                if (!slip_req) begin
                    state_d = PH_FILL;              // emit
                    beat_d  = '0;
                    load_en = 1'b1;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_FILL;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // Output register: strobe aligned with the holding-register update.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= load_en;
        end
    end

    assign word_valid = valid_q;

endmodule

// File: rtl/ddrdes_word_assembler.sv
// Moves both chains into the rising-edge domain, interleaves them
// (rise sample first) and loads the holding register.
module ddrdes_word_assembler #(
    parameter int HALF_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HALF_W-1:0]   rise_taps,
    input  logic [HALF_W-1:0]   fall_taps,
    input  logic                load_en,
    output logic [2*HALF_W-1:0] word_out
);

    localparam int WORD_W = 2 * HALF_W;

    logic [HALF_W-1:0] rise_al_q;   // rise chain delayed one cycle to line up
    logic [HALF_W-1:0] fall_rt_q;   // fall chain copied onto the rising edge
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        rise_al_q <= rise_taps;
        fall_rt_q <= fall_taps;
    end

    generate
        for (genvar i = 0; i < HALF_W; i++) begin : g_pair
            assign merged[WORD_W-1-2*i] = rise_al_q[HALF_W-1-i];
            assign merged[WORD_W-2-2*i] = fall_rt_q[HALF_W-1-i];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load_en) begin
            hold_q <= merged;
        end
    end

    assign word_out = hold_q;

endmodule

// File: rtl/ddr_word_deser.sv
module ddr_word_deser #(
    parameter int WORD_W = 12
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              slip_req,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    localparam int HALF_W = WORD_W / 2;

    logic [HALF_W-1:0] rise_taps;
    logic [HALF_W-1:0] fall_taps;
    logic              load_en;

    ddrdes_edge_chain #(.HALF_W(HALF_W), .FALL_EDGE(1'b0)) u_rise (
        .clk  (bit_clk),
        .din  (ser_in),
        .taps (rise_taps)
    );

    ddrdes_edge_chain #(.HALF_W(HALF_W), .FALL_EDGE(1'b1)) u_fall (
        .clk  (bit_clk),
        .din  (ser_in),
        .taps (fall_taps)
    );

    ddrdes_phase_fsm #(.HALF_W(HALF_W)) u_fsm (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .slip_req   (slip_req),
        .load_en    (load_en),
        .word_valid (word_valid)
    );

    ddrdes_word_assembler #(.HALF_W(HALF_W)) u_asm (
        .clk       (bit_clk),
        .rst_n     (rst_n),
        .rise_taps (rise_taps),
        .fall_taps (fall_taps),
        .load_en   (load_en),
        .word_out  (word_out)
    );

endmodule

// File: rtl/ddrdes_checker.sv
module ddrdes_checker #(
    parameter int WORD_W = 12
) (
    input logic              bit_clk,
    input logic              rst_n,
    input logic              slip_req,
    input logic [WORD_W-1:0] word_out,
    input logic              word_valid
);

    localparam int HALF_W = WORD_W / 2;

    logic [15:0] gap_q;    // edges since the last sampled strobe (or reset)
    logic [15:0] slips_q;  // slip edges inside that window

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            slips_q <= '0;
        end else if (word_valid) begin
            gap_q   <= 16'd1;
            slips_q <= {15'd0, slip_req};
        end else begin
            gap_q   <= gap_q + 16'd1;
            slips_q <= slips_q + {15'd0, slip_req};
        end
    end

    // R1: reset holds the strobe low
    assert_reset_quiet_R1: assert property (@(posedge bit_clk)
        !rst_n |-> (!word_valid && word_out == '0));

    // R3 / R6: strobe spacing is the word period plus the slips seen
    assert_strobe_spacing_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        word_valid |-> (gap_q == 16'(HALF_W) + slips_q));

    // R3: strobe lasts a single cycle
    assert_strobe_single_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R5: holding register steady between strobes
    assert_hold_stable_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));

    // R6: no load at an edge where slip is sampled
    assert_slip_blocks_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        slip_req |=> !word_valid);

endmodule

bind ddr_word_deser ddrdes_checker #(.WORD_W(WORD_W)) u_chk (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .slip_req   (slip_req),
    .word_out   (word_out),
    .word_valid (word_valid)
);

// File: tb/sim_ddr_word_deser.sv
module sim_ddr_word_deser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        ser_in = 1'b0;
    logic        slip_req = 1'b0;
    logic [11:0] word_out;
    logic        word_valid;

    always #10 clk = ~clk;   // 50 MHz

    ddr_word_deser #(.WORD_W(12)) u0 (
        .bit_clk    (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .slip_req   (slip_req),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    int checks = 0;
    int errors = 0;

    // Bench model of the requirements.
    int          mcnt;       // cycle position in word period (R3, R6)
    int          since_rst;
    int          pushes;
    logic [7:0]  rh, fh;     // index 0 = newest rise / fall sample
    logic [11:0] last_word;
    logic [15:0] lfsr = 16'hACE1;

    // Each entry: {bits sent, word expected on word_out}
    localparam logic [23:0] VEC [0:7] = '{
        {12'hA5C, 12'hA5C}, {12'h000, 12'h000}, {12'hFFF, 12'hFFF},
        {12'h800, 12'h800}, {12'h001, 12'h001}, {12'h555, 12'h555},
        {12'hAAA, 12'hAAA}, {12'h3C9, 12'h3C9}
    };

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R2 / R4: word loaded at edge j = samples j-7 .. j-2, rise first
    function automatic logic [11:0] exp_word();
        logic [11:0] w;
        for (int i = 0; i < 6; i++) begin
            w[11-2*i] = rh[6-i];
            w[10-2*i] = fh[6-i];
        end
        return w;
    endfunction

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic model_clear();
        mcnt = 0; since_rst = 0; pushes = 0;
        rh = '0; fh = '0; last_word = '0;
    endtask

    // One bit-clock cycle: r sampled at the rising edge, f at the next falling edge.
    // Entered and left at falling edge + 2.
    task automatic cyc(input logic r, input logic f, input logic s);
        logic ld;
        ser_in = r;
        slip_req = s;
        @(posedge clk);
        #2;
        ser_in = f;
        since_rst++;
        ld = (!s) && (mcnt == 5);
        if (!s) mcnt = (mcnt == 5) ? 0 : mcnt + 1;
        if (s)
            chk("R6 valid", {11'd0, word_valid}, {11'd0, ld});
        else if (since_rst == 6)
            chk("R1 first valid", {11'd0, word_valid}, {11'd0, ld});
        else
            chk("R3 valid", {11'd0, word_valid}, {11'd0, ld});
        if (ld) begin
            if (pushes >= 7) chk("R2/R4 word", word_out, exp_word());
            last_word = word_out;
        end else begin
            chk("R5 hold", word_out, last_word);
        end
        rh = {rh[6:0], r};
        fh = {fh[6:0], f};
        pushes++;
        @(negedge clk);
        #2;
        slip_req = 1'b0;
    endtask

    task automatic send_word(input logic [11:0] w);
        for (int i = 0; i < 6; i++) cyc(w[11-2*i], w[10-2*i], 1'b0);
    endtask

    task automatic rand_cycles(input int n);
        for (int i = 0; i < n; i++) cyc(next_bit(), next_bit(), 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        #1;
        chk("R1 reset valid", {11'd0, word_valid}, 12'd0);
        chk("R1 reset word", word_out, 12'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        #2;
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        #1 rst_n = 1'b0;
        #1;
        chk("R1 reset valid", {11'd0, word_valid}, 12'd0);
        chk("R1 reset word", word_out, 12'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        #2;
        rst_n = 1'b1;
        model_clear();

        // Table walk: 4 fillers put word 0 at cycles 5..10 (loads at edge 12).
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 8; k++) begin
            send_word(VEC[k][23:12]);
            if (k > 0) chk("R2 table", word_out, VEC[k-1][11:0]);
        end
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R2 table last", word_out, VEC[7][11:0]);

        // R6: single slip, then a double slip, then a slip on the load cycle.
        cyc(next_bit(), next_bit(), 1'b1);
        rand_cycles(20);
        cyc(next_bit(), next_bit(), 1'b1);
        cyc(next_bit(), next_bit(), 1'b1);
        rand_cycles(20);
        while (mcnt != 5) cyc(next_bit(), next_bit(), 1'b0);
        cyc(next_bit(), next_bit(), 1'b1);
        rand_cycles(14);

        // R1: reset in the middle of a word, then restart.
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        do_reset();
        rand_cycles(14);
        for (int i = 0; i < 3; i++) cyc(next_bit(), next_bit(), 1'b1);
        rand_cycles(20);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(100000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule